// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block gathers the interrupt sources of an audio codec controller into one 32-bit interrupt status word and a single interrupt output. It keeps the small source registers itself: two response-ring flags (interrupt and overrun), a per-codec state-change word with its wake-enable mask, and the interrupt control mask. Per-stream interrupt flags are taken from bit 26 of each stream control word, which arrives on a flat input bus. Software writes and hardware source events do not change the status word directly. They schedule a recompute, and the status word is registered in the next cycle.

The status word has three parts. Bits 7:0 carry the stream flags. Bit 30 is the controller summary. Bit 31 is the global summary, which is set when any collected source survives the control mask. The output is the global summary gated by control bit 31. It leaves the block either as a level line or, in message-signalled mode, as a one-cycle pulse on each rising edge of that level. On reset, every present codec marks its state-change bit, so a wake interrupt can follow as soon as software enables it.

Top module: `aud_irq_agg`

## Requirements
- R1: Status bit i (0 to NSTREAM-1) equals bit 26 of stream control word i, which sits at `stream_ctl[i*32+26]`. No other bit of a stream word has any effect. Status bits 29 down to NSTREAM always read 0.
- R2: Status bit 30 is set when the ring interrupt flag is set, or the ring overrun flag is set, or the bitwise AND of state-change status and wake enable is nonzero.
- R3: Status bit 31 is set exactly when status bits 30:0 ANDed with the interrupt control mask are nonzero.
- R4: With `msi_mode` low, `irq_line` equals status bit 31 AND mask bit 31, one cycle after the status word updates.
- R5: With `msi_mode` high, `irq_line` stays 0 and `msi_pulse` is high for exactly one cycle per rising edge of that level. It does not pulse again while the level stays high.
- R6: A write with `wr_sel` 0 to 4, or any source event, recomputes the status word at the next clock edge after the edge that took it. Otherwise the status word holds, even when `stream_ctl` changes.
- R7: A write with `wr_sel`=0 clears the ring interrupt flag where `wr_data[0]` is 1 and the overrun flag where `wr_data[1]` is 1. Zero bits leave the flags unchanged. `ring_irq_evt` and `ring_ovr_evt` set the flags.
- R8: A write with `wr_sel`=1 clears the state-change bits where `wr_data` is 1. `wake_evt` sets bits. `wr_sel`=2 loads the wake enable, and `wr_sel`=3 loads the 32-bit control mask. `wr_sel`=4 only triggers a recompute.
- R9: When a source event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R10: Reset (synchronous, active high) loads state-change status from `codec_present` and zeroes wake enable, mask, ring flags and outputs. Write selects 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| codec_present | input | NCODEC | Codecs attached; loaded into state-change status on reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 ring status, 1 state-change, 2 wake enable, 3 mask, 4 stream control |
| wr_data | input | 32 | Write data |
| ring_irq_evt | input | 1 | Sets ring interrupt flag |
| ring_ovr_evt | input | 1 | Sets ring overrun flag |
| wake_evt | input | NCODEC | Sets state-change bits |
| stream_ctl | input | NSTREAM*32 | Stream control words, stream i in bits i*32+31 to i*32 |
| msi_mode | input | 1 | 1 selects pulse delivery |
| int_sts | output | 32 | Registered interrupt status word |
| irq_line | output | 1 | Level interrupt |
| msi_pulse | output | 1 | Message-signalled notification pulse |

## Verification
The two functions that can collide are the write-one-to-clear of a ring flag and a hardware event that sets the same flag. The bench drives the clearing write and `ring_irq_evt` in the same cycle. It then judges the result from status bit 30 after the recompute, which must stay set. A second overlap arises in pulse mode: a recompute that keeps the level high must not start a second pulse. The bench checks this by counting pulse cycles across repeated writes.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  localparam int WORD_W         = 32;
  localparam int CTRL_BIT       = 30;
  localparam int GLOBAL_BIT     = 31;
  localparam int STREAM_IRQ_BIT = 26;
  localparam int RING_IRQ_CLR   = 0;
  localparam int RING_OVR_CLR   = 1;

  localparam logic [2:0] SEL_RING   = 3'd0;
  localparam logic [2:0] SEL_CODEC  = 3'd1;
  localparam logic [2:0] SEL_WAKE   = 3'd2;
  localparam logic [2:0] SEL_MASK   = 3'd3;
  localparam logic [2:0] SEL_STREAM = 3'd4;
endpackage

// File: rtl/aud_irq_src.sv
module aud_irq_src
  import aud_irq_pkg::*;
#(
  parameter int NCODEC = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NCODEC-1:0]   codec_present,
  input  logic                wr_en,
  input  logic [2:0]          wr_sel,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic                ring_irq_evt,
  input  logic                ring_ovr_evt,
  input  logic [NCODEC-1:0]   wake_evt,
  output logic                ring_irq_q,
  output logic                ring_ovr_q,
  output logic [NCODEC-1:0]   state_q,
  output logic [NCODEC-1:0]   wake_en_q,
  output logic [WORD_W-1:0]   mask_q,
  output logic                reeval_q
);
  logic wr_ring, wr_codec, wr_wake, wr_mask, wr_known, any_evt;

  always_comb begin
    wr_ring  = wr_en && (wr_sel == SEL_RING);
    wr_codec = wr_en && (wr_sel == SEL_CODEC);
    wr_wake  = wr_en && (wr_sel == SEL_WAKE);
    wr_mask  = wr_en && (wr_sel == SEL_MASK);
    wr_known = wr_en && (wr_sel <= SEL_STREAM);
    any_evt  = ring_irq_evt || ring_ovr_evt || (|wake_evt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_irq_q <= 1'b0;
      ring_ovr_q <= 1'b0;
      state_q    <= codec_present;
      wake_en_q  <= '0;
      mask_q     <= '0;
      reeval_q   <= 1'b1;
    end else begin
      ring_irq_q <= ring_irq_evt | (ring_irq_q & ~(wr_ring & wr_data[RING_IRQ_CLR]));
      ring_ovr_q <= ring_ovr_evt | (ring_ovr_q & ~(wr_ring & wr_data[RING_OVR_CLR]));
      state_q    <= wake_evt | (state_q & ~(wr_codec ? wr_data[NCODEC-1:0] : '0));
      if (wr_wake) wake_en_q <= wr_data[NCODEC-1:0];
      if (wr_mask) mask_q    <= wr_data;
      reeval_q   <= wr_known | any_evt;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ring_irq_evt |=> ring_irq_q); // R9
  AST_RING_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_ring && wr_data[RING_IRQ_CLR] && !ring_irq_evt) |=> !ring_irq_q); // R7
  AST_WAKE_SETS: assert property (@(posedge clk) disable iff (rst)
    (|wake_evt) |=> ((state_q & $past(wake_evt)) == $past(wake_evt))); // R8
endmodule

// File: rtl/aud_irq_merge.sv
module aud_irq_merge
  import aud_irq_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int NCODEC  = 4
) (
  input  logic [NSTREAM*WORD_W-1:0] stream_ctl,
  input  logic                      ring_irq,
  input  logic                      ring_ovr,
  input  logic [NCODEC-1:0]         state,
  input  logic [NCODEC-1:0]         wake_en,
  input  logic [WORD_W-1:0]         mask,
  output logic [WORD_W-1:0]         sts_next,
  output logic                      level_next
);
  logic [NSTREAM-1:0] stream_bits;
  logic [WORD_W-1:0]  src;
  logic               ctrl, summary;

  for (genvar g = 0; g < NSTREAM; g++) begin : g_stream
    assign stream_bits[g] = stream_ctl[g*WORD_W + STREAM_IRQ_BIT];
  end

  always_comb begin
    ctrl = ring_irq | ring_ovr | (|(state & wake_en));
    src = '0;
    src[NSTREAM-1:0] = stream_bits;
    src[CTRL_BIT] = ctrl;
    summary = |(src & mask);
    sts_next = src;
    sts_next[GLOBAL_BIT] = summary;
    level_next = summary & mask[GLOBAL_BIT];
  end
endmodule

// File: rtl/aud_irq_deliver.sv
module aud_irq_deliver (
  input  logic clk,
  input  logic rst,
  input  logic level_q,
  input  logic msi_mode,
  output logic irq_line,
  output logic msi_pulse
);
  logic level_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_prev <= 1'b0;
      irq_line   <= 1'b0;
      msi_pulse  <= 1'b0;
    end else begin
      level_prev <= level_q;
      irq_line   <= level_q & ~msi_mode;
      msi_pulse  <= msi_mode & level_q & ~level_prev;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    msi_pulse |=> !msi_pulse); // R5
  AST_LINE_QUIET: assert property (@(posedge clk) disable iff (rst)
    msi_mode |=> !irq_line); // R5
  AST_LINE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !msi_mode |=> (irq_line == $past(level_q))); // R4
endmodule

// File: rtl/aud_irq_agg.sv
module aud_irq_agg
  import aud_irq_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int NCODEC  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NCODEC-1:0]         codec_present,
  input  logic                      wr_en,
  input  logic [2:0]                wr_sel,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic                      ring_irq_evt,
  input  logic                      ring_ovr_evt,
  input  logic [NCODEC-1:0]         wake_evt,
  input  logic [NSTREAM*WORD_W-1:0] stream_ctl,
  input  logic                      msi_mode,
  output logic [WORD_W-1:0]         int_sts,
  output logic                      irq_line,
  output logic                      msi_pulse
);
  localparam logic [WORD_W-1:0] LIVE_MASK =
    ((WORD_W'(1) << NSTREAM) - WORD_W'(1)) | (WORD_W'(3) << CTRL_BIT);

  logic                ring_irq_q, ring_ovr_q, reeval_q, level_q, level_next;
  logic [NCODEC-1:0]   state_q, wake_en_q;
  logic [WORD_W-1:0]   mask_q, sts_next;

  aud_irq_src #(.NCODEC(NCODEC)) u_src (
    .clk(clk), .rst(rst), .codec_present(codec_present),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ring_irq_evt(ring_irq_evt), .ring_ovr_evt(ring_ovr_evt), .wake_evt(wake_evt),
    .ring_irq_q(ring_irq_q), .ring_ovr_q(ring_ovr_q), .state_q(state_q),
    .wake_en_q(wake_en_q), .mask_q(mask_q), .reeval_q(reeval_q)
  );

  aud_irq_merge #(.NSTREAM(NSTREAM), .NCODEC(NCODEC)) u_merge (
    .stream_ctl(stream_ctl), .ring_irq(ring_irq_q), .ring_ovr(ring_ovr_q),
    .state(state_q), .wake_en(wake_en_q), .mask(mask_q),
    .sts_next(sts_next), .level_next(level_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_sts <= '0;
      level_q <= 1'b0;
    end else if (reeval_q) begin
      int_sts <= sts_next;
      level_q <= level_next;
    end
  end

  aud_irq_deliver u_deliver (
    .clk(clk), .rst(rst), .level_q(level_q), .msi_mode(msi_mode),
    .irq_line(irq_line), .msi_pulse(msi_pulse)
  );

  AST_STS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reeval_q |=> $stable(int_sts)); // R6
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (int_sts & ~LIVE_MASK) == '0); // R1
  AST_GLOBAL_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst)
    int_sts[GLOBAL_BIT] |-> (int_sts[GLOBAL_BIT-1:0] != '0)); // R3
endmodule

// File: tb/aud_irq_agg_test.sv
module aud_irq_agg_test;
  localparam int NSTREAM = 8;
  localparam int NCODEC  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCODEC-1:0] codec_present = 4'b0101;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [31:0] wr_data = '0;
  logic ring_irq_evt = 1'b0, ring_ovr_evt = 1'b0;
  logic [NCODEC-1:0] wake_evt = '0;
  logic [NSTREAM*32-1:0] stream_ctl = '0;
  logic msi_mode = 1'b0;
  logic [31:0] int_sts;
  logic irq_line, msi_pulse;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  aud_irq_agg #(.NSTREAM(NSTREAM), .NCODEC(NCODEC)) uut (
    .clk(clk), .rst(rst), .codec_present(codec_present), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .ring_irq_evt(ring_irq_evt),
    .ring_ovr_evt(ring_ovr_evt), .wake_evt(wake_evt), .stream_ctl(stream_ctl),
    .msi_mode(msi_mode), .int_sts(int_sts), .irq_line(irq_line), .msi_pulse(msi_pulse)
  );

  typedef struct packed {
    logic [7:0]  strm;
    logic        rirq;
    logic        rovr;
    logic [3:0]  wevt;
    logic [3:0]  wen;
    logic [31:0] ctl;
    logic [31:0] exp_sts;
    logic        exp_irq;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{8'h00, 1'b0, 1'b0, 4'h0, 4'h0, 32'h0000_0000, 32'h0000_0000, 1'b0},
    '{8'h05, 1'b0, 1'b0, 4'h0, 4'h0, 32'h8000_0001, 32'h8000_0005, 1'b1},
    '{8'h05, 1'b0, 1'b0, 4'h0, 4'h0, 32'h0000_0001, 32'h8000_0005, 1'b0},
    '{8'h80, 1'b0, 1'b0, 4'h0, 4'h0, 32'h8000_0001, 32'h0000_0080, 1'b0},
    '{8'h00, 1'b1, 1'b0, 4'h0, 4'h0, 32'hC000_0000, 32'hC000_0000, 1'b1},
    '{8'h00, 1'b0, 1'b1, 4'h0, 4'h0, 32'h8000_0000, 32'h4000_0000, 1'b0},
    '{8'h00, 1'b0, 1'b0, 4'h2, 4'h2, 32'hC000_0000, 32'hC000_0000, 1'b1},
    '{8'h00, 1'b0, 1'b0, 4'h2, 4'h4, 32'hC000_0000, 32'h0000_0000, 1'b0},
    '{8'hFF, 1'b1, 1'b0, 4'h0, 4'h0, 32'hC000_00FF, 32'hC000_00FF, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_streams(input logic [7:0] bits);
    for (int i = 0; i < NSTREAM; i++)
      stream_ctl[i*32 +: 32] = 32'h0800_0002 | (32'(bits[i]) << 26);
  endtask

  task automatic pulse_ring(input logic irq, input logic ovr);
    @(negedge clk);
    ring_irq_evt = irq; ring_ovr_evt = ovr;
    @(negedge clk);
    ring_irq_evt = 1'b0; ring_ovr_evt = 1'b0;
  endtask

  task automatic pulse_wake(input logic [3:0] w);
    @(negedge clk);
    wake_evt = w;
    @(negedge clk);
    wake_evt = '0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int pulses;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    // R10 reset state
    check("R10 sts after reset", int_sts, 32'h0);
    check("R10 irq after reset", {31'b0, irq_line}, 32'h0);
    check("R10 msi after reset", {31'b0, msi_pulse}, 32'h0);
    // R10 absent codec 1 not marked, present codec 0 marked
    do_write(3'd2, 32'h2);
    do_write(3'd3, 32'hC000_0000);
    @(negedge clk);
    check("R10 absent codec", int_sts, 32'h0);
    do_write(3'd2, 32'h1);
    @(negedge clk);
    check("R10 present codec wake", int_sts, 32'hC000_0000);
    @(negedge clk);
    check("R4 level line", {31'b0, irq_line}, 32'h1);

    // R1 R2 R3 R4 vector table
    for (int v = 0; v < 9; v++) begin
      do_write(3'd0, 32'h3);
      do_write(3'd1, 32'hF);
      set_streams(VECS[v].strm);
      if (VECS[v].rirq || VECS[v].rovr) pulse_ring(VECS[v].rirq, VECS[v].rovr);
      if (VECS[v].wevt != 0) pulse_wake(VECS[v].wevt);
      do_write(3'd2, {28'b0, VECS[v].wen});
      do_write(3'd3, VECS[v].ctl);
      @(negedge clk);
      check($sformatf("R1/R2/R3 vector %0d status", v), int_sts, VECS[v].exp_sts);
      @(negedge clk);
      check($sformatf("R4 vector %0d line", v), {31'b0, irq_line}, {31'b0, VECS[v].exp_irq});
    end

    // R6 stale without a write
    set_streams(8'h00);
    repeat (3) @(negedge clk);
    check("R6 status holds on stream change", int_sts, 32'hC000_00FF);
    do_write(3'd6, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    check("R10 unused select ignored", int_sts, 32'hC000_00FF);
    do_write(3'd4, 32'h0);
    @(negedge clk);
    check("R6 stream write recomputes", int_sts, 32'hC000_0000);

    // R7 write-one-to-clear
    do_write(3'd0, 32'h0);
    @(negedge clk);
    check("R7 zero write keeps flag", int_sts, 32'hC000_0000);
    do_write(3'd0, 32'h2);
    @(negedge clk);
    check("R7 overrun clear keeps irq flag", int_sts, 32'hC000_0000);
    do_write(3'd0, 32'h1);
    @(negedge clk);
    check("R7 irq flag cleared", int_sts, 32'h0);
    @(negedge clk);
    check("R4 line drops", {31'b0, irq_line}, 32'h0);

    // R9 set and clear together
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h1; ring_irq_evt = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ring_irq_evt = 1'b0;
    @(negedge clk);
    check("R9 set wins over clear", int_sts, 32'hC000_0000);
    do_write(3'd0, 32'h1);

    // R8 state-change clear and wake set
    do_write(3'd2, 32'h8);
    pulse_wake(4'h8);
    @(negedge clk);
    check("R8 wake event sets bit", int_sts, 32'hC000_0000);
    do_write(3'd1, 32'h7);
    @(negedge clk);
    check("R8 clear of other bits keeps bit", int_sts, 32'hC000_0000);
    do_write(3'd1, 32'h8);
    @(negedge clk);
    check("R8 state bit cleared", int_sts, 32'h0);
    @(negedge clk);

    // R5 message-signalled delivery
    msi_mode = 1'b1;
    pulse_ring(1'b1, 1'b0);
    @(negedge clk);
    check("R5 no pulse before level", {31'b0, msi_pulse}, 32'h0);
    @(negedge clk);
    check("R5 pulse on rise", {31'b0, msi_pulse}, 32'h1);
    check("R5 line quiet", {31'b0, irq_line}, 32'h0);
    @(negedge clk);
    check("R5 pulse one cycle", {31'b0, msi_pulse}, 32'h0);
    pulses = 0;
    fork
      begin
        do_write(3'd2, 32'h8);
        do_write(3'd4, 32'h0);
        repeat (3) @(negedge clk);
      end
      begin
        repeat (8) begin
          @(negedge clk);
          if (msi_pulse) pulses++;
        end
      end
    join
    check("R5 no repeat while high", 32'(pulses), 32'h0);
    do_write(3'd0, 32'h1);
    repeat (3) @(negedge clk);
    pulse_ring(1'b1, 1'b0);
    @(negedge clk); @(negedge clk);
    check("R5 second rise pulses", {31'b0, msi_pulse}, 32'h1);

    finish_run();
  end
endmodule